// File: doc/BRIEF.md
# Channel-Gain List Scan Sequencer

This block is the sequencer for an analog-input path on a 16-bit register bus. Software fills a small list in which each entry names a multiplexer channel and a gain code. It then primes the multiplexer with the first entry. After that, each software or external trigger issues one conversion-start strobe to an external converter. Each completed conversion moves the list pointer on to the next entry. The pointer wraps to entry zero after the last entry, so a multi-channel scan repeats without software stepping through it.

The bus decoding stays outside the block. The bus reaches it as four strobes (list control write, A/D control write, command write, data read) and one shared write-data word. The block returns a status word and a result word. The result can be offset-converted to two's complement. After every multiplexer change the block holds a settling window of a parameterised length, and it accepts no trigger until that window ends. When a result is lost because the previous one was never read, the block flags an overrun.

Top module: `adc_scan_seq`

## Requirements
- R1: A list control write with bit 15 set opens loading, restarts the write index at entry 0, and stores bits 3:0 as the entry count minus one. While loading is open, each A/D control write stores one entry at the next index, taking the channel from bits 3:0 and the gain code from bits 5:4.
- R2: A list control write with bit 15 clear ends loading. After that, A/D control writes store no entry.
- R3: Command bit 1 (preload) puts list entry 0 on `mux_chan`/`mux_gain` and restarts the settling window. Status bit 8 is then high for exactly SETTLE cycles. Status bits 3:0 and 5:4 mirror the current channel and gain.
- R4: Command bit 2 (software trigger) gives a one-cycle `conv_start`. A trigger that arrives while status bit 8 (settling) or status bit 10 (conversion pending) is high is ignored.
- R5: On `conv_done` the block captures `conv_result` and sets status bit 7. A `data_rd` strobe clears status bit 7.
- R6: Each completed conversion moves the list pointer to the next entry and drives that entry on the multiplexer outputs. After the last entry the pointer wraps to entry 0 and sets status bit 9. The multiplexer outputs do not change while a conversion is pending.
- R7: A conversion that completes while status bit 7 is still set sets status bit 15 (overrun). Status bit 15 stays set until command bit 0 (init) is written, which also clears bit 7 and bit 9.
- R8: A/D control bit 6 is stored on every A/D control write. `irq` is high exactly when that enable and status bit 7 are both set.
- R9: `rdata` carries the captured result in bits DW-1:0 with zeros above. When list control bit 14 is set, result bit DW-1 is inverted (two's-complement mode).
- R10: Command bit 3 arms the external trigger. A rising edge on `ext_trig` then starts a conversion under the same conditions as R4. While the external trigger is not armed, `ext_trig` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wdata | input | 16 | Write data shared by all write strobes |
| lctl_wr | input | 1 | List control register write strobe |
| actl_wr | input | 1 | A/D control register write strobe |
| cmd_wr | input | 1 | Command register write strobe |
| data_rd | input | 1 | Result read strobe |
| ext_trig | input | 1 | External trigger level |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | DW | Converter result, valid with conv_done |
| mux_chan | output | 4 | Multiplexer channel select |
| mux_gain | output | 2 | Gain select |
| conv_start | output | 1 | One-cycle conversion start |
| status | output | 16 | Status word |
| rdata | output | 16 | Formatted result |
| irq | output | 1 | Done interrupt |

## Verification
A wrong list pointer shows up on the first conversion after the fault. The converter model builds each result from the channel and gain it saw on the multiplexer outputs, so the bench compares that result with its own list and catches a misrouted entry one conversion later. A settling counter that is off by one changes the count of busy cycles after a preload, and that count is checked exactly. A done or overrun flag that sticks wrongly appears in the status word on the cycle after the read or the init.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef struct packed {
    logic [1:0] gain;
    logic [3:0] chan;
  } scan_entry_t;

  // status word bit positions
  localparam int ST_ERR  = 15;
  localparam int ST_PEND = 10;
  localparam int ST_SCAN = 9;
  localparam int ST_BUSY = 8;
  localparam int ST_DONE = 7;
  localparam int ST_IEN  = 6;

  // command word bits
  localparam int CMD_INIT = 0;
  localparam int CMD_PRE  = 1;
  localparam int CMD_TRIG = 2;
  localparam int CMD_ARM  = 3;

  // list control bits
  localparam int LC_LOAD = 15;
  localparam int LC_TWOS = 14;

  // keep dw low bits, optionally flip the top data bit
  function automatic logic [15:0] fmt_result(input logic [15:0] raw, input int dw,
                                             input logic twos);
    logic [15:0] v;
    v = '0;
    for (int i = 0; i < 16; i++)
      if (i < dw) v[i] = raw[i];
    if (twos) v[dw-1] = ~v[dw-1];
    return v;
  endfunction

endpackage

// File: rtl/adc_scan_list.sv
module adc_scan_list
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  scan_entry_t     wentry,
  input  logic [AW-1:0]   raddr,
  output scan_entry_t     rentry
);

  scan_entry_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wentry;
    end
  end

  always_comb rentry = mem[raddr];

endmodule

// File: rtl/adc_scan_settle.sv
module adc_scan_settle #(
  parameter int SETTLE = 4,
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (load)       cnt <= CW'(SETTLE);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clear |=> busy); // R3
  AST_SETTLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy); // R3

endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result
  import adc_scan_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          rd,
  input  logic          clear,
  input  logic          twos,
  output logic          done,
  output logic          err,
  output logic [15:0]   rdata
);

  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (clear) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (cap) data_q <= cap_data;
      if (cap && done && !rd) err <= 1'b1;
      if (cap)     done <= 1'b1;
      else if (rd) done <= 1'b0;
    end
  end

  assign rdata = fmt_result(16'(data_q), DW, twos);

  AST_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !cap && !clear |=> !done); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clear |=> err); // R7
  AST_CAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !clear |=> done); // R5

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 12,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   wdata,
  input  logic          lctl_wr,
  input  logic          actl_wr,
  input  logic          cmd_wr,
  input  logic          data_rd,
  input  logic          ext_trig,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_result,
  output logic [3:0]    mux_chan,
  output logic [1:0]    mux_gain,
  output logic          conv_start,
  output logic [15:0]   status,
  output logic [15:0]   rdata,
  output logic          irq
);

  localparam int AW = $clog2(DEPTH);

  logic          load_en, twos_q, ien_q, armed_q, ext_q, pend_q, scan_q, start_q;
  logic [AW-1:0] len_q, wptr, rptr, nptr, raddr;
  scan_entry_t   cur, rentry, wentry;
  logic          settle_busy, done, err;

  // named events
  logic init_ev, pre_ev, soft_ev, ext_rise, start_ev, adv_ev, wrap_ev, list_we;

  assign init_ev  = cmd_wr & wdata[CMD_INIT];
  assign pre_ev   = cmd_wr & wdata[CMD_PRE] & ~wdata[CMD_INIT];
  assign soft_ev  = cmd_wr & wdata[CMD_TRIG] & ~wdata[CMD_INIT];
  assign ext_rise = armed_q & ext_trig & ~ext_q;
  assign start_ev = (soft_ev | ext_rise) & ~settle_busy & ~pend_q & ~init_ev;
  assign adv_ev   = conv_done & ~init_ev;
  assign wrap_ev  = adv_ev & (rptr == len_q);
  assign nptr     = wrap_ev ? '0 : AW'(rptr + 1'b1);
  assign raddr    = pre_ev ? '0 : nptr;
  assign list_we  = actl_wr & load_en;
  assign wentry   = '{gain: wdata[5:4], chan: wdata[3:0]};

  adc_scan_list #(.DEPTH(DEPTH)) u_list (
    .clk(clk), .rst_n(rst_n), .we(list_we), .waddr(wptr), .wentry(wentry),
    .raddr(raddr), .rentry(rentry));

  adc_scan_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(pre_ev | adv_ev), .clear(init_ev),
    .busy(settle_busy));

  adc_scan_result #(.DW(DW)) u_result (
    .clk(clk), .rst_n(rst_n), .cap(conv_done), .cap_data(conv_result),
    .rd(data_rd), .clear(init_ev), .twos(twos_q), .done(done), .err(err),
    .rdata(rdata));

  // list control and load mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en <= 1'b0;
      twos_q  <= 1'b0;
      len_q   <= '0;
      wptr    <= '0;
    end else begin
      if (lctl_wr) begin
        load_en <= wdata[LC_LOAD];
        twos_q  <= wdata[LC_TWOS];
        len_q   <= wdata[AW-1:0];
        if (wdata[LC_LOAD]) wptr <= '0;
      end else if (list_we) begin
        wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : AW'(wptr + 1'b1);
      end
    end
  end

  // A/D control: interrupt enable is taken from every write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (actl_wr) ien_q <= wdata[ST_IEN];
  end

  // scan pointer, multiplexer, triggering
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      cur     <= '0;
      armed_q <= 1'b0;
      ext_q   <= 1'b0;
      pend_q  <= 1'b0;
      scan_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ext_q   <= ext_trig;
      start_q <= start_ev;
      if (init_ev) begin
        rptr    <= '0;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
        scan_q  <= 1'b0;
      end else begin
        if (cmd_wr && wdata[CMD_ARM]) armed_q <= 1'b1;
        if (start_ev)    pend_q <= 1'b1;
        else if (adv_ev) pend_q <= 1'b0;
        if (pre_ev) begin
          rptr   <= '0;
          cur    <= rentry;
          scan_q <= 1'b0;
        end else if (adv_ev) begin
          rptr <= nptr;
          cur  <= rentry;
          if (wrap_ev) scan_q <= 1'b1;
        end
      end
    end
  end

  assign mux_chan   = cur.chan;
  assign mux_gain   = cur.gain;
  assign conv_start = start_q;
  assign irq        = done & ien_q;
  assign status     = {err, 4'b0, pend_q, scan_q, settle_busy, done, ien_q,
                       cur.gain, cur.chan};

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
  AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pend_q || $past(init_ev)); // R4
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !conv_done && !init_ev && !pre_ev |=> $stable(mux_chan) && $stable(mux_gain)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev && !pre_ev |=> (rptr == '0) && scan_q); // R6
  AST_PRELOAD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ev |=> (rptr == '0) && settle_busy); // R3
  AST_NO_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    actl_wr && !load_en && !lctl_wr |=> $stable(wptr)); // R2

endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
  localparam int DEPTH = 16, DW = 12, SETTLE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] wdata = '0;
  logic lctl_wr = 0, actl_wr = 0, cmd_wr = 0, data_rd = 0, ext_trig = 0;
  logic conv_done = 0;
  logic [DW-1:0] conv_result = '0;
  logic [3:0] mux_chan;
  logic [1:0] mux_gain;
  logic conv_start, irq;
  logic [15:0] status, rdata;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.DEPTH(DEPTH), .DW(DW), .SETTLE(SETTLE)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .lctl_wr(lctl_wr), .actl_wr(actl_wr),
    .cmd_wr(cmd_wr), .data_rd(data_rd), .ext_trig(ext_trig), .conv_done(conv_done),
    .conv_result(conv_result), .mux_chan(mux_chan), .mux_gain(mux_gain),
    .conv_start(conv_start), .status(status), .rdata(rdata), .irq(irq));

  int nchk = 0, nfail = 0, start_cnt = 0, done_cnt = 0, cycles = 0;
  int lat = 0, seq = 0;
  logic [15:0] expq[$];
  logic [3:0] tb_chan [16];
  logic [1:0] tb_gain [16];
  int blen = 1, bptr = 0, bseq = 0;
  logic btwos = 0;

  // converter model: result encodes the channel and gain seen on the pins
  always @(negedge clk) begin
    cycles++;
    conv_done = 1'b0;
    if (conv_start) begin
      lat = 3;
      start_cnt++;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        conv_done   = 1'b1;
        conv_result = {mux_chan, mux_gain, 6'(seq)};
        seq++;
        done_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [15:0] d);
    wdata = d;
    if (which == 0) lctl_wr = 1; else if (which == 1) actl_wr = 1; else cmd_wr = 1;
    @(negedge clk);
    lctl_wr = 0; actl_wr = 0; cmd_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && (status[8] || status[10]); i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_val(input int p, input int s, input logic tw);
    logic [11:0] r;
    r = {tb_chan[p], tb_gain[p], 6'(s)};
    if (tw) r[11] = ~r[11];
    return {4'b0, r};
  endfunction

  task automatic load_list(input int n, input logic tw, input logic ien);
    wr(0, {1'b1, tw, 10'b0, 4'(n - 1)});
    for (int i = 0; i < n; i++) wr(1, {9'b0, ien, tb_gain[i], tb_chan[i]});
    wr(0, {1'b0, tw, 10'b0, 4'(n - 1)});
    blen = n; btwos = tw;
  endtask

  task automatic preload();
    wr(2, 16'h0002);
    bptr = 0;
  endtask

  // driver: trigger and push the expected result
  task automatic trigger();
    wait_idle();
    wr(2, 16'h0004);
    expq.push_back(exp_val(bptr, bseq, btwos));
    bptr = (bptr == blen - 1) ? 0 : bptr + 1;
    bseq++;
  endtask

  // monitor: wait for done, pop and compare, then read
  task automatic drain(input string req, input bit chk_irq);
    logic [15:0] e;
    for (int i = 0; i < 100 && !status[7]; i++) @(negedge clk);
    check(status[7] == 1'b1, "R5 done flag", status[7], 1);
    if (chk_irq) check(irq == 1'b1, "R8 irq with done", irq, 1);
    e = expq.pop_front();
    check(rdata == e, req, rdata, e);
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
    check(status[7] == 1'b0, "R5 done cleared by read", status[7], 0);
    if (chk_irq) check(irq == 1'b0, "R8 irq after read", irq, 0);
  endtask

  initial begin
    wait (cycles > 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 16'h0 && rdata == 16'h0 && !conv_start && !irq, "reset state", status, 0);

    // R1 list load, R3 preload and settling
    tb_chan[0] = 4'd5;  tb_gain[0] = 2'd1;
    tb_chan[1] = 4'd9;  tb_gain[1] = 2'd2;
    tb_chan[2] = 4'd15; tb_gain[2] = 2'd3;
    load_list(3, 1'b0, 1'b0);
    preload();
    check(mux_chan == 4'd5 && mux_gain == 2'd1, "R1 entry 0 on mux", {mux_gain, mux_chan}, 6'h15);
    check(status[5:0] == 6'h15, "R3 status mirrors mux", status[5:0], 6'h15);
    n = 0;
    while (status[8] && n < 50) begin n++; @(negedge clk); end
    check(n == SETTLE, "R3 settle cycles", n, SETTLE);

    // R4 trigger while settling is ignored
    preload();
    s0 = start_cnt;
    wr(2, 16'h0004);
    wait_idle();
    repeat (6) @(negedge clk);
    check(start_cnt == s0, "R4 trigger during settling ignored", start_cnt, s0);

    // R4 trigger while pending is ignored, start is one pulse
    wait_idle();
    s0 = start_cnt;
    trigger();
    wr(2, 16'h0004);
    drain("R1 R6 result entry 0", 0);
    check(start_cnt == s0 + 1, "R4 single start while pending", start_cnt, s0 + 1);

    // R6 stepping and wrap
    check(mux_chan == 4'd9, "R6 advance to entry 1", mux_chan, 9);
    check(status[9] == 1'b0, "R6 no wrap yet", status[9], 0);
    trigger(); drain("R6 result entry 1", 0);
    trigger(); drain("R6 result entry 2", 0);
    check(status[9] == 1'b1, "R6 wrap flag", status[9], 1);
    check(mux_chan == 4'd5 && mux_gain == 2'd1, "R6 wrap to entry 0", mux_chan, 5);
    trigger(); drain("R6 result after wrap", 0);

    // R2 writes without load enable store nothing
    wr(1, 16'h0037);
    preload();
    check(mux_chan == 4'd5 && mux_gain == 2'd1, "R2 entry 0 untouched", {mux_gain, mux_chan}, 6'h15);

    // R8 interrupt enable, R9 two's complement
    tb_chan[0] = 4'd2; tb_gain[0] = 2'd0;
    tb_chan[1] = 4'd12; tb_gain[1] = 2'd2;
    load_list(2, 1'b1, 1'b1);
    preload();
    check(status[6] == 1'b1, "R8 enable stored", status[6], 1);
    trigger(); drain("R9 twos result entry 0", 1);
    trigger(); drain("R9 twos result entry 1", 1);
    check(irq == 1'b0, "R8 irq idle", irq, 0);

    // R7 overrun and init
    load_list(2, 1'b0, 1'b0);
    preload();
    trigger();
    for (int i = 0; i < 100 && !status[7]; i++) @(negedge clk);
    trigger();
    for (int i = 0; i < 100 && status[10]; i++) @(negedge clk);
    check(status[15] == 1'b1, "R7 overrun set", status[15], 1);
    repeat (3) @(negedge clk);
    check(status[15] == 1'b1, "R7 overrun held", status[15], 1);
    wr(2, 16'h0001);
    check(status[15] == 1'b0 && status[7] == 1'b0, "R7 init clears", status, 0);
    expq.delete();

    // R10 external trigger
    preload();
    wait_idle();
    s0 = start_cnt;
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    repeat (8) @(negedge clk);
    check(start_cnt == s0, "R10 disarmed ext ignored", start_cnt, s0);
    wr(2, 16'h0008);
    wait_idle();
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    expq.push_back(exp_val(bptr, bseq, btwos));
    bptr = (bptr == blen - 1) ? 0 : bptr + 1;
    bseq++;
    drain("R10 ext triggered result", 0);
    check(start_cnt == s0 + 1, "R10 armed ext starts", start_cnt, s0 + 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule